// File: doc/BRIEF.md
# Oscillator Run-Enable and Wake Controller

This block decides whether one clock oscillator keeps running. It produces two outputs that together hold the oscillator on: a synchronous run enable, governed by the CPU's oscillator-off status bit and by whether the CPU state machines have gone idle, and an asynchronous wake line, raised directly from a peripheral's wake request so that a stopped oscillator can restart with no clock present. The oscillator runs whenever either output is high. Once its clock is back and the CPU has restarted, the synchronous enable takes over. The wake line is then released through a two-stage path that behaves like a reset synchronizer: immediate assertion, deassertion on the second clock edge after the request is withdrawn.

The controller is clocked by the clock of the oscillator it controls. When both outputs are low, that clock stops. One instance serves the fast oscillator, fed from the status bit that stops it in the light and deep sleep modes. Another instance serves the low-frequency oscillator, fed from the bit that stops it only in the deepest mode. A parameter removes the feature, and both outputs are then tied high.

The enable logic is a three-state machine. ST_ON holds the enable high. ST_DRAIN means the off bit is set while the CPU is still finishing the instruction that set it, and the enable stays high. ST_OFF drives the enable low. The named transitions are: ON to DRAIN on "off requested, CPU busy"; ON to OFF on "off requested, CPU idle"; DRAIN to OFF on "instruction retired"; DRAIN to ON on "off withdrawn"; and OFF to ON on "CPU restarted or off withdrawn".

Top module: `osc_wake_ctrl`

## Requirements
- R1: With the clock stopped and osc_enable low, raising wkup_req while gie is 1 drives osc_wkup high at once, with no clock edge, and osc_enable stays low.
- R2: On each rising clock edge, osc_enable takes the value NOT(osc_off AND cpu_idle). In particular, it rises on the first edge at which the CPU is busy (cpu_idle = 0) or the off bit is clear.
- R3: While cpu_idle is 0, osc_enable remains 1 even when osc_off is 1. It falls only on the edge at which osc_off and cpu_idle are both 1.
- R4: After (wkup_req AND gie) falls to 0, osc_wkup stays 1 through the first following rising edge and is 0 after the second.
- R5: If wkup_req is still 1 when gie returns to 1, osc_wkup goes high again immediately.
- R6: Reset (rst_n = 0) forces osc_enable to 1 and osc_wkup to 0 asynchronously, so the oscillator runs during and after reset.
- R7: With FEATURE_EN = 0, osc_enable and osc_wkup are both 1 for every input pattern.
- R8: While gie is 0, wkup_req has no effect: once released, osc_wkup stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock derived from the controlled oscillator; stops while both outputs are low |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_off | input | 1 | CPU status bit requesting this oscillator off |
| cpu_idle | input | 1 | CPU state machines are idle (the current instruction has retired) |
| gie | input | 1 | Global interrupt enable flag |
| wkup_req | input | 1 | Asynchronous wake request from peripherals |
| osc_enable | output | 1 | Synchronous run enable for the oscillator |
| osc_wkup | output | 1 | Asynchronous wake line for the oscillator |

## Verification
Two functions can coincide on a single edge: the enable dropping, because the off bit and cpu_idle are both 1, and the wake line rising or still being held by a pending request. The random phase deliberately pairs every off-and-idle cycle with an active wake request. This forces the enable to fall while the wake line keeps the clock alive, and the bench model checks both outputs at every falling edge. A directed sequence separates the two: it lets the clock stop, raises a wake request with no clock present, restarts the CPU, and then withdraws the interrupt enable. The bench checks that the enable rises on the first edge after the restart and that the wake line falls exactly on the second edge after the withdrawal.

// File: rtl/osc_wake_pkg.sv
package osc_wake_pkg;

    // Run-enable state machine encoding
    typedef enum logic [1:0] {
        ST_ON    = 2'd0,
        ST_DRAIN = 2'd1,
        ST_OFF   = 2'd2
    } osc_state_e;

endpackage

// File: rtl/osc_run_fsm.sv
module osc_run_fsm
    import osc_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_off,
    input  logic cpu_idle,
    output logic osc_enable
);

    osc_state_e state_q;
    osc_state_e state_nxt;

    // next-state decision
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_ON: begin
                if (osc_off && cpu_idle)       state_nxt = ST_OFF;   // off requested, CPU idle
                else if (osc_off)              state_nxt = ST_DRAIN; // off requested, CPU busy
            end
            ST_DRAIN: begin
                if (!osc_off)                  state_nxt = ST_ON;    // off withdrawn
                else if (cpu_idle)             state_nxt = ST_OFF;   // instruction retired
            end
            ST_OFF: begin
                if (!osc_off || !cpu_idle)     state_nxt = ST_ON;    // CPU restarted or off withdrawn
            end
            default:                           state_nxt = ST_ON;
        endcase
    end

    // state register, reset leaves the oscillator running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ON;
        else        state_q <= state_nxt;
    end

    // outputs
    always_comb begin
        osc_enable = (state_q != ST_OFF);
    end

    // R3: a busy CPU keeps the oscillator enabled on the next edge
    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_idle |=> osc_enable);

    // R2: cleared off bit re-enables on the next edge
    p_off_clear_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_off |=> osc_enable);

    // R3: off bit with idle CPU disables on the next edge
    p_idle_off_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off && cpu_idle) |=> !osc_enable);

    // R3: every fall of the enable is caused by off bit plus idle
    p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_enable) |-> $past(osc_off && cpu_idle));

endmodule

// File: rtl/osc_wake_sync.sv
module osc_wake_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic wkup_out
);

    localparam int CNT_W = $clog2(SYNC_STAGES + 1);

    logic [SYNC_STAGES-1:0] chain_q;

    // asynchronous set, synchronous release through the chain
    always_ff @(posedge clk or negedge rst_n or posedge set_req) begin
        if (!rst_n)       chain_q <= '0;
        else if (set_req) chain_q <= '1;
        else              chain_q <= {chain_q[SYNC_STAGES-2:0], 1'b0};
    end

    assign wkup_out = chain_q[SYNC_STAGES-1];

    // checker: edges seen since the set request went away
    logic [CNT_W-1:0] quiet_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    quiet_q <= '0;
        else if (set_req)                              quiet_q <= '0;
        else if (quiet_q != CNT_W'(SYNC_STAGES))       quiet_q <= quiet_q + 1'b1;
    end

    // R1: an active set request shows on the wake line
    p_async_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |-> wkup_out);

    // R4: released once the chain has drained
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q == CNT_W'(SYNC_STAGES) && !set_req) |-> !wkup_out);

    // R4: no early release, still high on the first edge after the drop
    p_no_early_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req ##1 !set_req) |-> wkup_out);

endmodule

// File: rtl/osc_wake_ctrl.sv
module osc_wake_ctrl #(
    parameter bit FEATURE_EN  = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_off,
    input  logic cpu_idle,
    input  logic gie,
    input  logic wkup_req,
    output logic osc_enable,
    output logic osc_wkup
);

    generate
        if (FEATURE_EN) begin : g_ctrl
            logic wake_set;

            // wake request qualified by the interrupt enable
            assign wake_set = wkup_req & gie;

            osc_run_fsm u_run_fsm (
                .clk        (clk),
                .rst_n      (rst_n),
                .osc_off    (osc_off),
                .cpu_idle   (cpu_idle),
                .osc_enable (osc_enable)
            );

            osc_wake_sync #(
                .SYNC_STAGES (SYNC_STAGES)
            ) u_wake_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_req  (wake_set),
                .wkup_out (osc_wkup)
            );

            // R8: with interrupts masked a released wake line stays low
            p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!gie && !osc_wkup) ##1 !gie |-> !osc_wkup);

            // R5: restored interrupt enable with pending request wakes
            p_rewake_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (gie && wkup_req) |-> osc_wkup);
        end else begin : g_tied
            assign osc_enable = 1'b1;
            assign osc_wkup   = 1'b1;
        end
    endgenerate

endmodule

// File: tb/osc_wake_ctrl_bench.sv
module osc_wake_ctrl_bench;

    logic clk      = 1'b0;
    logic rst_n    = 1'b1;
    logic osc_off  = 1'b0;
    logic cpu_idle = 1'b0;
    logic gie      = 1'b0;
    logic wkup_req = 1'b0;
    logic osc_enable, osc_wkup;
    logic dis_enable, dis_wkup;

    int n_checks = 0;
    int n_fails  = 0;
    int n_edges  = 0;
    bit finished = 1'b0;

    osc_wake_ctrl u_osc_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .osc_off(osc_off), .cpu_idle(cpu_idle),
        .gie(gie), .wkup_req(wkup_req), .osc_enable(osc_enable), .osc_wkup(osc_wkup)
    );

    osc_wake_ctrl #(.FEATURE_EN(1'b0)) u_osc_wake_ctrl_off (
        .clk(clk), .rst_n(rst_n), .osc_off(osc_off), .cpu_idle(cpu_idle),
        .gie(gie), .wkup_req(wkup_req), .osc_enable(dis_enable), .osc_wkup(dis_wkup)
    );

    // 125 MHz oscillator model that stops while both outputs are low
    initial begin
        forever begin
            #4ns;
            if (osc_enable === 1'b1 || osc_wkup === 1'b1) clk = ~clk;
            else                                          clk = 1'b0;
        end
    end

    // expected-value model from the requirements
    logic exp_en   = 1'b1;
    int   wk_left  = 0;

    function automatic logic next_enable(input logic off_b, input logic idle_b);
        return !(off_b && idle_b);
    endfunction

    function automatic logic wkup_expect(input logic req_b, input logic gie_b, input int left);
        return (req_b && gie_b) || (left > 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_en  <= 1'b1;
            wk_left <= 0;
        end else begin
            n_edges <= n_edges + 1;
            exp_en  <= next_enable(osc_off, cpu_idle);
            if (wkup_req && gie) wk_left <= 2;
            else if (wk_left > 0) wk_left <= wk_left - 1;
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_model(input string req);
        check_bit({req, " enable"}, osc_enable, exp_en);
        check_bit({req, " wkup"}, osc_wkup, wkup_expect(wkup_req, gie, wk_left));
        check_bit("R7 tied enable", dis_enable, 1'b1);
        check_bit("R7 tied wkup", dis_wkup, 1'b1);
    endtask

    task automatic drive(input logic off_b, input logic idle_b, input logic gie_b, input logic req_b);
        osc_off = off_b; cpu_idle = idle_b; gie = gie_b; wkup_req = req_b;
    endtask

    initial begin
        #2ms;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'h5eed_0a1c);
        #1ns;
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 1'b1);
        #30ns;
        // R6: reset state while inputs ask for sleep and wake
        check_bit("R6 reset enable", osc_enable, 1'b1);
        check_bit("R6 reset wkup", osc_wkup, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_model("R6 after reset");
        end

        // R3: off bit set while busy keeps the enable high
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (3) begin
            @(negedge clk);
            check_bit("R3 busy hold", osc_enable, 1'b1);
        end

        // R8: masked request has no effect
        drive(1'b0, 1'b1, 1'b0, 1'b1);
        repeat (4) begin
            @(negedge clk);
            check_bit("R8 masked request", osc_wkup, 1'b0);
        end
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);

        // R3: instruction retires with the off bit set, clock stops
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        #100ns;
        begin
            int edges_before;
            edges_before = n_edges;
            #200ns;
            check_bit("R3 enable dropped", osc_enable, 1'b0);
            check_bit("R3 clock stopped", logic'(n_edges == edges_before), 1'b1);
        end

        // R1: asynchronous wake with no clock
        wkup_req = 1'b1;
        gie      = 1'b1;
        #1ns;
        check_bit("R1 wkup async", osc_wkup, 1'b1);
        check_bit("R1 enable still low", osc_enable, 1'b0);
        @(negedge clk);
        check_model("R1 resumed");

        // R2: CPU restarts, enable comes back on the next edge
        cpu_idle = 1'b0;
        @(negedge clk);
        check_bit("R2 enable after restart", osc_enable, 1'b1);
        check_model("R2 model");

        // R4: interrupt entry clears gie, wkup released on second edge
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check_bit("R4 held first edge", osc_wkup, 1'b1);
        @(negedge clk);
        check_bit("R4 released second edge", osc_wkup, 1'b0);

        // R5: gie restored with request still pending
        gie = 1'b1;
        #1ns;
        check_bit("R5 rewake", osc_wkup, 1'b1);
        @(negedge clk);
        check_model("R5 model");
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check_model("R4 quiet");

        // random phase: off-and-idle always paired with a live wake request
        for (int i = 0; i < 1500; i++) begin
            logic r_off, r_idle, r_gie, r_req;
            r_off  = 1'($urandom_range(0, 1));
            r_idle = 1'($urandom_range(0, 1));
            r_gie  = 1'($urandom_range(0, 1));
            r_req  = 1'($urandom_range(0, 1));
            if (r_off && r_idle) begin
                r_gie = 1'b1;
                r_req = 1'b1;
            end
            drive(r_off, r_idle, r_gie, r_req);
            @(negedge clk);
            check_model("R2/R4 random");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule